// File: doc/BRIEF.md
# Fixed-Frequency Line Test Pattern Generator

This block feeds a serializer with a steady stream of 10-bit code groups so that the quality of a serial line can be measured: eye opening, jitter and baseline wander. A small mode input picks the stimulus. The high-frequency pattern toggles on every bit. The low-frequency pattern holds five ones and then five zeros. The mixed pattern alternates word by word between the two running-disparity forms of the K28.5 comma, which combines short and long runs. It is a pure source: there is no matching checker on the receive side.

One word leaves the block on every clock, so every clock edge is a word boundary. The mode input is sampled at each edge, and the word built from it appears on the output just after that edge. A word never mixes two patterns. The word that carries a new mode is flagged not valid, as is the first word after reset, so that downstream capture logic can discard the transition word.

Top module: `line_pattern_gen`

## Requirements
- R1: With mode code 2'b00 every emitted word is 10'b1010101010 (bit 9 is the leftmost character).
- R2: With mode code 2'b01 every emitted word is 10'b0011111000.
- R3: With mode code 2'b10 consecutive words alternate between 10'b0011111010 and 10'b1100000101.
- R4: Every run of mixed-mode words starts with 10'b0011111010, whether the run follows reset or a change from another mode.
- R5: Mode code 2'b11 is reserved and produces the same words and strobe as code 2'b00; a switch between 2'b11 and 2'b00 does not count as a mode change.
- R6: While rst_n is low the strobe is 0 and the word is all zeros. The first word after reset is released carries the strobe low.
- R7: The mode sampled at a clock edge sets the word output just after that edge. If that mode differs from the mode of the previous word, the strobe is low for that one word only. It is high again on the next word if the mode holds.
- R8: Every word emitted with the strobe high is one of the four code groups listed in R1 to R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock; one code group per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Pattern select: 00 high, 01 low, 10 mixed, 11 reserved (high) |
| word_o | output | 10 | Code group to the serializer, bit 9 leftmost |
| word_vld_o | output | 1 | High when word_o belongs to a settled pattern |

## Verification
A mode change and the mixed-pattern phase decision can fall on the same word. Entering mixed mode must blank the strobe and also restart the alternation at the negative-disparity form, even when the previous mixed run ended on either form. The bench provokes this by leaving mixed mode after both odd and even run lengths and returning, and by changing the mode on every word. It judges each word against its own model of run length and blanking. Reset in the middle of a mixed run is used in the same way to check that the restart also happens after reset.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int WORD_W = 10;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_HIGH = 2'd0,
    PM_LOW  = 2'd1,
    PM_MIX  = 2'd2
  } pat_mode_e;

  localparam logic [WORD_W-1:0] CW_HIGH  = 10'b1010101010;
  localparam logic [WORD_W-1:0] CW_LOW   = 10'b0011111000;
  localparam logic [WORD_W-1:0] CW_MIX_N = 10'b0011111010;
  localparam logic [WORD_W-1:0] CW_MIX_P = 10'b1100000101;

  // Reserved select code aliases the high-frequency pattern.
  function automatic pat_mode_e decode_mode(input logic [MODE_W-1:0] sel);
    case (sel)
      2'd1:    return PM_LOW;
      2'd2:    return PM_MIX;
      default: return PM_HIGH;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pattern_word(input pat_mode_e m, input logic ph);
    case (m)
      PM_LOW:  return CW_LOW;
      PM_MIX:  return ph ? CW_MIX_P : CW_MIX_N;
      default: return CW_HIGH;
    endcase
  endfunction

  function automatic logic legal_word(input logic [WORD_W-1:0] w);
    return (w == CW_HIGH) || (w == CW_LOW) || (w == CW_MIX_N) || (w == CW_MIX_P);
  endfunction
endpackage

// File: rtl/lpg_mode_track.sv
module lpg_mode_track
  import lpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  output pat_mode_e         next_mode_o,
  output pat_mode_e         cur_mode_o,
  output logic              seen_o,
  output logic              blank_o,
  output logic              valid_o
);
  pat_mode_e mode_q;
  logic      seen_q;
  logic      valid_q;

  assign next_mode_o = decode_mode(mode_sel);
  // A word is blanked if it is the first after reset or its mode differs.
  assign blank_o     = !seen_q || (next_mode_o != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PM_HIGH;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      mode_q  <= next_mode_o;
      seen_q  <= 1'b1;
      valid_q <= !blank_o;
    end
  end

  assign cur_mode_o = mode_q;
  assign seen_o     = seen_q;
  assign valid_o    = valid_q;

  assert_blank_drops_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |=> !valid_o);
  assert_steady_keeps_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_o |=> valid_o);
  assert_first_word_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_o |=> !valid_o);
endmodule

// File: rtl/lpg_mix_phase.sv
module lpg_mix_phase
  import lpg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pat_mode_e next_mode_i,
  input  pat_mode_e cur_mode_i,
  input  logic      seen_i,
  output logic      phase_d_o
);
  logic phase_q;
  logic continue_w;

  // Phase flips only while a mixed run continues; any fresh run restarts at 0.
  assign continue_w = seen_i && (next_mode_i == PM_MIX) && (cur_mode_i == PM_MIX);
  assign phase_d_o  = continue_w ? ~phase_q : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d_o;
  end
endmodule

// File: rtl/lpg_word_reg.sv
module lpg_word_reg
  import lpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pat_mode_e         next_mode_i,
  input  logic              phase_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= pattern_word(next_mode_i, phase_i);
  end

  assign word_o = word_q;

  assert_word_legal_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    legal_word(word_o) || (word_o == '0));
endmodule

// File: rtl/line_pattern_gen.sv
module line_pattern_gen
  import lpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  pat_mode_e next_mode_w;
  pat_mode_e cur_mode_w;
  logic      seen_w;
  logic      blank_w;
  logic      valid_w;
  logic      phase_w;
  logic [WORD_W-1:0] word_w;

  lpg_mode_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .next_mode_o (next_mode_w),
    .cur_mode_o  (cur_mode_w),
    .seen_o      (seen_w),
    .blank_o     (blank_w),
    .valid_o     (valid_w)
  );

  lpg_mix_phase u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .next_mode_i (next_mode_w),
    .cur_mode_i  (cur_mode_w),
    .seen_i      (seen_w),
    .phase_d_o   (phase_w)
  );

  lpg_word_reg u_word (
    .clk         (clk),
    .rst_n       (rst_n),
    .next_mode_i (next_mode_w),
    .phase_i     (phase_w),
    .word_o      (word_w)
  );

  assign word_o     = word_w;
  assign word_vld_o = valid_w;

  assert_valid_word_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> legal_word(word_o));
  assert_mix_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_o && cur_mode_w == PM_MIX && $past(word_vld_o) && $past(cur_mode_w) == PM_MIX)
    |-> (word_o != $past(word_o)));
  assert_mix_run_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_w && !word_vld_o && cur_mode_w == PM_MIX) |-> (word_o == CW_MIX_N));
  assert_fixed_word_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_o && $past(word_vld_o) && cur_mode_w != PM_MIX) |-> $stable(word_o));
  assert_reserved_is_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_w && $past(mode_sel) == 2'b11) |-> (word_o == CW_HIGH));
endmodule

// File: tb/line_pattern_gen_tb.sv
module line_pattern_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [9:0] word_o;
  logic       word_vld_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Bench model of the pattern rules.
  bit b_seen = 0;
  int b_prev = 0;
  int b_run  = 0;

  localparam logic [9:0] W_HI = 10'b1010101010;
  localparam logic [9:0] W_LO = 10'b0011111000;
  localparam logic [9:0] W_MN = 10'b0011111010;
  localparam logic [9:0] W_MP = 10'b1100000101;

  line_pattern_gen dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .word_o(word_o), .word_vld_o(word_vld_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, cycles=%0d expected<=20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive one mode, let one word out, compare against the model.
  task automatic step(input logic [1:0] m, input string tag);
    int dec;
    bit ev;
    logic [9:0] ew;
    mode_sel = m;
    @(posedge clk);
    #1;
    dec = (m == 2'b11) ? 0 : int'(m);
    ev  = b_seen && (dec == b_prev);
    if (dec == 2) begin
      b_run = (b_seen && b_prev == 2) ? b_run + 1 : 0;
      ew = (b_run % 2 == 1) ? W_MP : W_MN;
    end else begin
      b_run = 0;
      ew = (dec == 1) ? W_LO : W_HI;
    end
    b_seen = 1;
    b_prev = dec;
    chk({tag, " word"}, word_o, ew);
    chk({tag, " strobe"}, {9'b0, word_vld_o}, {9'b0, ev});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #3;
    b_seen = 0; b_prev = 0; b_run = 0;
    chk("R6 reset word", word_o, 10'b0);
    chk("R6 reset strobe", {9'b0, word_vld_o}, 10'b0);
    @(posedge clk); #1;
    chk("R6 reset held word", word_o, 10'b0);
    chk("R6 reset held strobe", {9'b0, word_vld_o}, 10'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_high();
    for (int i = 0; i < 5; i++) step(2'b00, "R1 high");
  endtask

  task automatic t_low();
    for (int i = 0; i < 5; i++) step(2'b01, "R2 low");
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 7; i++) step(2'b10, "R3 mixed alternation");
  endtask

  task automatic t_reserved();
    step(2'b11, "R5 reserved after high");
    step(2'b11, "R5 reserved");
    step(2'b00, "R5 back to high no blank");
    step(2'b01, "R5 low");
    step(2'b11, "R5 reserved after low");
  endtask

  task automatic t_restart();
    step(2'b10, "R4 enter mix");
    step(2'b10, "R4 mix");
    step(2'b01, "R7 leave even");
    step(2'b10, "R4 re-enter after even");
    step(2'b10, "R4 mix");
    step(2'b10, "R4 mix");
    step(2'b00, "R7 leave odd");
    step(2'b10, "R4 re-enter after odd");
  endtask

  task automatic t_fast_switch();
    step(2'b00, "R7 switch");
    step(2'b10, "R7 switch");
    step(2'b01, "R7 switch");
    step(2'b10, "R7 switch");
    step(2'b00, "R7 switch");
    step(2'b00, "R7 settle");
  endtask

  task automatic t_reset_mid_mix();
    step(2'b10, "R4 pre-reset");
    step(2'b10, "R4 pre-reset");
    do_reset();
    step(2'b10, "R6 first word after reset");
    step(2'b10, "R4 mixed after reset");
  endtask

  initial begin
    #1;
    do_reset();
    step(2'b00, "R6 first word after reset");
    t_high();
    t_low();
    t_mixed();
    t_reserved();
    t_restart();
    t_fast_switch();
    t_reset_mid_mix();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule